// File: doc/BRIEF.md
# Frame-Addressed Partial Configuration Loader

This block takes a stream of 32-bit configuration words, one per valid cycle, and turns them into writes on the port of a configuration memory that is organised as separately addressed frames. A control processor or an internal configuration port feeds the stream. A frame pointer register chooses where data lands. A command can load that pointer, or it can open a burst of a stated number of data words. The pointer moves on by one frame each time a frame has been filled. Only frames inside the window owned by the reconfigurable region may be written. Any other address is refused and raises a sticky flag.

While a partial load is in progress, everything the region drives toward the static logic is replaced by a fixed safe value. That clamp starts with the first frame write. A desynchronise command ends the session. The block then gives the region one cycle of local reset and lifts the clamp in the cycle after. The region's registers therefore start from a known state without any power-on values. A request for the global start-up sequence would halt the static logic, so such a word is dropped and recorded in a sticky flag.

Top module: `pr_frame_loader`

## Requirements
- R1: After synchronous reset, mem_we, iso_active, region_rst, err_range and err_startup are all 0, and static_out equals region_out.
- R2: A command word with bits [31:30] = 01 loads the frame pointer from bits [FAR_W-1:0] and sets the word position within the frame to 0.
- R3: A command word with bits [31:30] = 10 announces a count N held in bits [CNT_W-1:0]. The next N valid words are data. Each in-range data word appears on mem_we/mem_frame/mem_word/mem_data in the cycle after it is accepted, with word positions 0, 1, 2 and so on. A count of 0 announces no data.
- R4: After FRAME_WORDS data words have been written into a frame, the frame pointer moves to the next frame and the word position goes back to 0.
- R5: A data word aimed at a frame outside REGION_LO..REGION_HI produces no write and sets err_range. Loading such an address with an 01 command also sets err_range.
- R6: A command word with bits [31:30] = 00 and bit 29 set is a start-up request. It is dropped, with no write and no region reset, and it sets err_startup.
- R7: A command word with bits [31:30] = 00 and bit 29 clear changes nothing.
- R8: iso_active rises together with the first frame write. While it is high, static_out carries SAFE_VAL in place of region_out.
- R9: A command word with bits [31:30] = 11, accepted while iso_active is high, gives region_rst high for exactly the next cycle. iso_active is low from two cycles after the word was presented. With iso_active low, such a word changes nothing.
- R10: Words that arrive inside an announced data burst are written as data, whatever their upper bits hold.
- R11: err_range and err_startup stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream word is present this cycle |
| in_word | input | WORD_W | Command or data word |
| region_out | input | OUT_W | Outputs of the reconfigurable region |
| static_out | output | OUT_W | Region outputs as seen by static logic, clamped during loading |
| mem_we | output | 1 | Configuration memory write strobe |
| mem_frame | output | FAR_W | Frame being written |
| mem_word | output | IDX_W | Word position within the frame |
| mem_data | output | WORD_W | Word being written |
| iso_active | output | 1 | Isolation of the region is in force |
| region_rst | output | 1 | One-cycle local reset to the region |
| err_range | output | 1 | Sticky: refused frame address |
| err_startup | output | 1 | Sticky: start-up request dropped |

## Verification
The bench builds the loader with four-word frames and a window of frames 4 to 6, with SAFE_VAL set to A5 hex. With these values a ten-word burst fills one frame, rolls into the next and stops part-way through the last frame of the window. A later burst starting at frame 6 then runs past the top edge of the window. The pointer rollover and the refusal of out-of-window writes can both be seen in a few dozen cycles. The clamp is checked by comparing static_out against A5 hex and against the region's own value on either side of the desynchronise sequence.

// File: rtl/pr_loader_pkg.sv
package pr_loader_pkg;

    typedef enum logic [1:0] {
        OP_CTRL   = 2'b00,
        OP_SETFAR = 2'b01,
        OP_BURST  = 2'b10,
        OP_DESYNC = 2'b11
    } op_e;

    localparam int STARTUP_BIT = 29;

    typedef struct packed {
        logic set_far;
        logic burst;
        logic desync;
        logic startup;
        logic data;
    } act_s;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/pr_cmd_parser.sv
module pr_cmd_parser
    import pr_loader_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output act_s              act
);
    logic [CNT_W-1:0] remain;
    op_e              op;

    always_comb begin
        op  = op_e'(in_word[WORD_W-1 -: 2]);
        act = '0;
        if (in_valid) begin
            if (remain != '0) begin
                act.data = 1'b1;
            end else begin
                case (op)
                    OP_CTRL:   act.startup = in_word[STARTUP_BIT];
                    OP_SETFAR: act.set_far = 1'b1;
                    OP_BURST:  act.burst   = (in_word[CNT_W-1:0] != '0);
                    OP_DESYNC: act.desync  = 1'b1;
                    default:   act         = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            remain <= '0;
        else if (act.burst) remain <= in_word[CNT_W-1:0];
        else if (act.data)  remain <= remain - 1'b1;
    end

    // R3
    burst_opens_chk: assert property (@(posedge clk) disable iff (rst)
        act.burst |=> (remain != '0));

endmodule

// File: rtl/pr_far_unit.sv
module pr_far_unit
    import pr_loader_pkg::*;
#(
    parameter int FAR_W       = 10,
    parameter int FRAME_WORDS = 8,
    parameter int REGION_LO   = 16,
    parameter int REGION_HI   = 23,
    localparam int IDX_W      = $clog2(FRAME_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [FAR_W-1:0] load_val,
    input  logic             advance,
    output logic [FAR_W-1:0] far,
    output logic [IDX_W-1:0] idx,
    output logic             far_ok,
    output logic             load_ok
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    assign far_ok  = in_window(32'(far), 32'(REGION_LO), 32'(REGION_HI));
    assign load_ok = in_window(32'(load_val), 32'(REGION_LO), 32'(REGION_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            far <= '0;
            idx <= '0;
        end else if (load) begin
            far <= load_val;
            idx <= '0;
        end else if (advance) begin
            if (idx == LAST_IDX) begin
                idx <= '0;
                far <= far + 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pr_iso_ctrl.sv
module pr_iso_ctrl #(
    parameter int               OUT_W    = 8,
    parameter logic [OUT_W-1:0] SAFE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             write_fire,
    input  logic             desync,
    input  logic [OUT_W-1:0] region_out,
    output logic [OUT_W-1:0] static_out,
    output logic             iso,
    output logic             region_rst
);
    always_ff @(posedge clk) begin
        if (rst) begin
            iso        <= 1'b0;
            region_rst <= 1'b0;
        end else begin
            region_rst <= desync && iso && !region_rst;
            if (write_fire)      iso <= 1'b1;
            else if (region_rst) iso <= 1'b0;
        end
    end

    assign static_out = iso ? SAFE_VAL : region_out;

    // R9
    rst_single_chk: assert property (@(posedge clk) disable iff (rst)
        region_rst |=> !region_rst);

    // R9
    iso_release_chk: assert property (@(posedge clk) disable iff (rst)
        (region_rst && !write_fire) |=> !iso);

endmodule

// File: rtl/pr_frame_loader.sv
module pr_frame_loader
    import pr_loader_pkg::*;
#(
    parameter int               WORD_W      = 32,
    parameter int               CNT_W       = 16,
    parameter int               FAR_W       = 10,
    parameter int               FRAME_WORDS = 8,
    parameter int               REGION_LO   = 16,
    parameter int               REGION_HI   = 23,
    parameter int               OUT_W       = 8,
    parameter logic [OUT_W-1:0] SAFE_VAL    = '0,
    localparam int              IDX_W       = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [OUT_W-1:0]  region_out,
    output logic [OUT_W-1:0]  static_out,
    output logic              mem_we,
    output logic [FAR_W-1:0]  mem_frame,
    output logic [IDX_W-1:0]  mem_word,
    output logic [WORD_W-1:0] mem_data,
    output logic              iso_active,
    output logic              region_rst,
    output logic              err_range,
    output logic              err_startup
);
    act_s             act;
    logic [FAR_W-1:0] far;
    logic [IDX_W-1:0] idx;
    logic             far_ok;
    logic             load_ok;
    logic             write_fire;

    pr_cmd_parser #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .act(act)
    );

    pr_far_unit #(
        .FAR_W(FAR_W), .FRAME_WORDS(FRAME_WORDS),
        .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)
    ) u_far (
        .clk(clk), .rst(rst),
        .load(act.set_far), .load_val(in_word[FAR_W-1:0]),
        .advance(act.data),
        .far(far), .idx(idx), .far_ok(far_ok), .load_ok(load_ok)
    );

    assign write_fire = act.data && far_ok;

    pr_iso_ctrl #(.OUT_W(OUT_W), .SAFE_VAL(SAFE_VAL)) u_iso (
        .clk(clk), .rst(rst),
        .write_fire(write_fire), .desync(act.desync),
        .region_out(region_out), .static_out(static_out),
        .iso(iso_active), .region_rst(region_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we      <= 1'b0;
            mem_frame   <= '0;
            mem_word    <= '0;
            mem_data    <= '0;
            err_range   <= 1'b0;
            err_startup <= 1'b0;
        end else begin
            mem_we <= write_fire;
            if (write_fire) begin
                mem_frame <= far;
                mem_word  <= idx;
                mem_data  <= in_word;
            end
            if ((act.data && !far_ok) || (act.set_far && !load_ok))
                err_range <= 1'b1;
            if (act.startup)
                err_startup <= 1'b1;
        end
    end

    // R8
    write_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> iso_active);

    // R5
    write_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((32'(mem_frame) >= 32'(REGION_LO)) && (32'(mem_frame) <= 32'(REGION_HI))));

    // R6
    startup_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        act.startup |=> (err_startup && !mem_we && !region_rst));

    // R11
    range_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_range |=> err_range);

endmodule

// File: tb/test_pr_frame_loader.sv
module test_pr_frame_loader;
    localparam int WORD_W = 32;
    localparam int FAR_W  = 8;
    localparam int FW     = 4;
    localparam int LO     = 4;
    localparam int HI     = 6;
    localparam int OUT_W  = 8;
    localparam logic [7:0] SAFE = 8'hA5;
    localparam logic [7:0] RVAL = 8'h3C;

    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0;
    logic [31:0] in_word = '0;
    logic [7:0] region_out = RVAL;
    logic [7:0] static_out;
    logic mem_we;
    logic [FAR_W-1:0] mem_frame;
    logic [1:0] mem_word;
    logic [31:0] mem_data;
    logic iso_active, region_rst, err_range, err_startup;

    int total = 0;
    int bad = 0;
    logic [41:0] expq[$];
    int bfar = 0;
    int bidx = 0;

    always #5 clk = ~clk;

    pr_frame_loader #(
        .WORD_W(WORD_W), .CNT_W(16), .FAR_W(FAR_W), .FRAME_WORDS(FW),
        .REGION_LO(LO), .REGION_HI(HI), .OUT_W(OUT_W), .SAFE_VAL(SAFE)
    ) i_pr_frame_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .region_out(region_out), .static_out(static_out),
        .mem_we(mem_we), .mem_frame(mem_frame), .mem_word(mem_word),
        .mem_data(mem_data), .iso_active(iso_active), .region_rst(region_rst),
        .err_range(err_range), .err_startup(err_startup)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = '0;
    endtask

    task automatic set_far(input int f);
        put({2'b01, 30'(f)});
        bfar = f;
        bidx = 0;
    endtask

    task automatic data(input logic [31:0] w);
        if (bfar >= LO && bfar <= HI)
            expq.push_back({8'(bfar), 2'(bidx), w});
        put(w);
        if (bidx == FW - 1) begin
            bidx = 0;
            bfar++;
        end else begin
            bidx++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        bfar = 0;
        bidx = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (expq.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R3/R5 unexpected write actual=%h expected=none",
                         {mem_frame, mem_word, mem_data});
            end else begin
                chk("R3 write", 64'({mem_frame, mem_word, mem_data}), 64'(expq.pop_front()));
            end
        end
    end

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 outputs", 64'({mem_we, iso_active, region_rst, err_range, err_startup}), 64'(0));
        chk("R1 passthrough", 64'(static_out), 64'(RVAL));

        // R2, R3, R8: one full frame at 5
        set_far(5);
        put({2'b10, 30'd4});
        for (int i = 0; i < 4; i++) data(32'h1000_0000 + 32'(i));
        @(negedge clk);
        chk("R8 iso", 64'(iso_active), 64'(1));
        chk("R8 clamp", 64'(static_out), 64'(SAFE));

        // R4, R10: ten words from frame 4; one looks like a desync command
        set_far(4);
        put({2'b10, 30'd10});
        for (int i = 0; i < 10; i++)
            data(i == 3 ? 32'hC000_0000 : 32'h2000_0100 + 32'(i));
        @(negedge clk);
        chk("R10 still isolated", 64'(iso_active), 64'(1));
        chk("R4 queue drained", 64'(expq.size()), 64'(0));

        // R7 NOP changes nothing
        put(32'h0000_0000);
        chk("R7 errors", 64'({err_range, err_startup, region_rst}), 64'(0));

        // R6 start-up request dropped
        put(32'h2000_0000);
        chk("R6 err_startup", 64'(err_startup), 64'(1));
        chk("R6 no reset", 64'(region_rst), 64'(0));

        // R3 count zero: next word is a command (NOP), not data
        put({2'b10, 30'd0});
        put(32'h0000_0001);
        @(negedge clk);
        chk("R3 zero count", 64'(expq.size()), 64'(0));

        // R9 desync with isolation active
        in_valid = 1'b1;
        in_word  = 32'hC000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 reset pulse", 64'({region_rst, iso_active}), 64'(2'b11));
        @(negedge clk);
        chk("R9 released", 64'({region_rst, iso_active}), 64'(0));
        chk("R9 passthrough", 64'(static_out), 64'(RVAL));

        // R9 desync without isolation
        put(32'hC000_0000);
        chk("R9 idle desync", 64'(region_rst), 64'(0));
        @(negedge clk);
        chk("R9 idle desync 2", 64'({region_rst, iso_active}), 64'(0));

        // R5 out-of-window address
        set_far(7);
        chk("R5 load flag", 64'(err_range), 64'(1));
        put({2'b10, 30'd2});
        data(32'hDEAD_0001);
        data(32'hDEAD_0002);
        @(negedge clk);
        chk("R5 no isolation", 64'(iso_active), 64'(0));

        // R11 sticky
        repeat (5) @(negedge clk);
        chk("R11 sticky", 64'({err_range, err_startup}), 64'(2'b11));

        // R5 burst running past the window edge, after fresh reset
        do_reset();
        chk("R1 errors cleared", 64'({err_range, err_startup}), 64'(0));
        set_far(6);
        chk("R5 in-window load", 64'(err_range), 64'(0));
        put({2'b10, 30'd6});
        for (int i = 0; i < 6; i++) data(32'h3000_0000 + 32'(i));
        @(negedge clk);
        chk("R5 crossing flag", 64'(err_range), 64'(1));
        chk("R5 queue drained", 64'(expq.size()), 64'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule